// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block holds a bank of programmable decode windows that steer 36-bit CPU physical addresses to device targets. Each window carries an enable, a 4-bit target ID, an 8-bit attribute, a size expressed as a mask in 64 KiB granules, and a base address. The lower-numbered windows also carry a remap pair, which moves the matched region to another place in the physical space. The windows above them never translate the address.

Software programs the windows through a single-cycle 32-bit register write port. Reads come back combinationally. The register map is irregular. The remappable windows sit at the bottom of the map with four words each. A four-word reserved gap follows them. The remaining windows follow the gap with two words each.

The lookup port is purely combinational. It takes an address and returns a hit flag, the target, the attribute and the translated address. When several windows match, the lowest-indexed window wins.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled, every register reads as zero and every lookup misses.
- R2: A window's control word reads back exactly as written. Its fields are: bit 0 enable, bits 7:4 target ID, bits 15:8 attribute, and bits 31:16 the size mask, which equals the window size in 64 KiB units minus one.
- R3: A base word stores only two fields: bits 31:16, which are address bits 31:16, and bits 3:0, which are address bits 35:32. All other bits read as zero.
- R4: Window n below NUM_REMAP (default 8) is laid out in four consecutive words starting at byte offset 16·n: control, base, remap-low, remap-high. Remap-low keeps bits 31:16 and remap-high keeps bits 3:0; all other bits read as zero.
- R5: Window n at or above NUM_REMAP has only control and base words. These sit at byte offset 16·NUM_REMAP + 16 + 8·(n − NUM_REMAP), which is 0x90 for window 8 and 0xE8 for window 19 with the defaults.
- R6: The four words between the low and high windows (bytes 0x80–0x8F by default) read as zero. Writes to them change no window.
- R7: An address hits an enabled window when two conditions hold: its bits 35:32 equal the base high field, and its bits 31:16 equal the base low field in every bit position where the size mask is zero.
- R8: A window whose enable bit is clear never hits, and writing zero to its control word removes it from decoding.
- R9: On a hit in a remappable window, the translated address is formed from three parts. Bits 35:32 come from remap-high. Bits 31:16 come from the address where the size mask is one and from remap-low elsewhere. Bits 15:0 come from the address.
- R10: On a hit in a window at or above NUM_REMAP, the translated address equals the lookup address.
- R11: When more than one enabled window hits, the outputs come from the lowest-indexed one.
- R12: On a miss the hit flag is low, target and attribute are zero, and the translated address equals the lookup address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, taken at the rising clock edge |
| reg_addr | input | RA_W | Register word index (byte offset divided by four) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| lk_addr | input | 36 | Physical address to decode |
| lk_hit | output | 1 | A window matched lk_addr |
| lk_target | output | 4 | Target ID of the winning window, zero on miss |
| lk_attr | output | 8 | Attribute of the winning window, zero on miss |
| lk_xaddr | output | 36 | Translated address |

## Verification
The assertions assume that reg_wr, reg_addr and reg_wdata are stable around each rising edge. The write-readback property also assumes that a word written at one edge is still addressed in the following cycle when it is compared. The bench changes all inputs only on falling edges and samples late in the low phase, so every registered write settles before the combinational read and lookup paths are observed. Window bases are programmed aligned to their size masks, so each programmed region is a contiguous range whose edges the lookup vectors probe directly.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int RA_W      = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [35:0]     lk_addr,
  output logic            lk_hit,
  output logic [3:0]      lk_target,
  output logic [7:0]      lk_attr,
  output logic [35:0]     lk_xaddr
);

  localparam int HOLE_W = NUM_REMAP * 4;
  localparam int HI_W   = HOLE_W + 4;
  localparam logic [RA_W-1:0] HOLE_LO = RA_W'(HOLE_W);
  localparam logic [RA_W-1:0] HOLE_HI = RA_W'(HI_W);

  logic [NUM_WIN-1:0] hit_w, en_w;
  logic [31:0]        rd_w  [NUM_WIN];
  logic [11:0]        ta_w  [NUM_WIN];
  logic [19:0]        xup_w [NUM_WIN];

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    logic [31:0] ctrl_q;
    logic [15:0] blo_q;
    logic [3:0]  bhi_q;
    logic        sel;
    logic [1:0]  fld;
    logic [31:0] rx;
    logic [15:0] msk;
    assign msk = ctrl_q[31:16];

    if (gi < NUM_REMAP) begin : g_lo
      localparam logic [RA_W-1:0] W0 = RA_W'(gi * 4);
      logic [15:0] rlo_q;
      logic [3:0]  rhi_q;
      assign sel = reg_addr[RA_W-1:2] == W0[RA_W-1:2];
      assign fld = reg_addr[1:0];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rlo_q <= '0;
          rhi_q <= '0;
        end else if (reg_wr && sel) begin
          if (fld == 2'd2) rlo_q <= reg_wdata[31:16];
          if (fld == 2'd3) rhi_q <= reg_wdata[3:0];
        end
      end
      assign rx = (fld == 2'd2) ? {rlo_q, 16'h0} :
                  (fld == 2'd3) ? {28'h0, rhi_q} : 32'h0;
      assign xup_w[gi] = {rhi_q, (rlo_q & ~msk) | (lk_addr[31:16] & msk)};
    end else begin : g_hi
      localparam logic [RA_W-1:0] W0 = RA_W'(HI_W + (gi - NUM_REMAP) * 2);
      assign sel = reg_addr[RA_W-1:1] == W0[RA_W-1:1];
      assign fld = {1'b0, reg_addr[0]};
      assign rx  = 32'h0;
      assign xup_w[gi] = lk_addr[35:16];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q <= '0;
        blo_q  <= '0;
        bhi_q  <= '0;
      end else if (reg_wr && sel) begin
        if (fld == 2'd0) ctrl_q <= reg_wdata;
        if (fld == 2'd1) begin
          blo_q <= reg_wdata[31:16];
          bhi_q <= reg_wdata[3:0];
        end
      end
    end

    assign rd_w[gi]  = !sel ? 32'h0 :
                       (fld == 2'd0) ? ctrl_q :
                       (fld == 2'd1) ? {blo_q, 12'h0, bhi_q} : rx;
    assign en_w[gi]  = ctrl_q[0];
    assign ta_w[gi]  = ctrl_q[15:4];
    assign hit_w[gi] = ctrl_q[0] && (lk_addr[35:32] == bhi_q) &&
                       (((lk_addr[31:16] ^ blo_q) & ~msk) == 16'h0);
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_WIN; i++) reg_rdata = reg_rdata | rd_w[i];
  end

  always_comb begin
    lk_hit    = 1'b0;
    lk_target = '0;
    lk_attr   = '0;
    lk_xaddr  = lk_addr;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_w[i]) begin
        lk_hit    = 1'b1;
        lk_target = ta_w[i][3:0];
        lk_attr   = ta_w[i][11:4];
        lk_xaddr  = {xup_w[i], lk_addr[15:0]};
      end
    end
  end

  // R12
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_target == 4'h0 && lk_attr == 8'h0 && lk_xaddr == lk_addr));

  // R8
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (en_w != '0));

  // R6
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= HOLE_LO && reg_addr < HOLE_HI) |-> reg_rdata == 32'h0);

  // R9
  offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_xaddr[15:0] == lk_addr[15:0]);

  // R2
  ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr) && $past(reg_addr) == '0 && reg_addr == '0) |->
      reg_rdata == $past(reg_wdata));

endmodule

// File: tb/addr_window_decoder_bench.sv
module addr_window_decoder_bench;
  localparam int PERIOD = 10;
  localparam int RA_W   = 10;
  localparam int NV     = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0;
  logic [RA_W-1:0] reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [35:0]     lk_addr = '0;
  logic            lk_hit;
  logic [3:0]      lk_target;
  logic [7:0]      lk_attr;
  logic [35:0]     lk_xaddr;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  addr_window_decoder #(.NUM_WIN(20), .NUM_REMAP(8), .RA_W(RA_W)) u_addr_window_decoder (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_target(lk_target), .lk_attr(lk_attr), .lk_xaddr(lk_xaddr)
  );

  // {address, hit, target, attr, translated}
  localparam logic [84:0] VEC [NV] = '{
    {36'h010034567, 1'b1, 4'h3, 8'h1E, 36'h2A0034567},  // R9 R11 both w0 and w1 hit
    {36'h320ABCDEF, 1'b1, 4'h7, 8'h55, 36'h320ABCDEF},  // R10 high window
    {36'h020ABCDEF, 1'b0, 4'h0, 8'h00, 36'h020ABCDEF},  // R7 R12 high bits differ
    {36'h010F00010, 1'b1, 4'h5, 8'h22, 36'h050F00010},  // R7 R9 w1 only
    {36'h0100FFFFF, 1'b1, 4'h3, 8'h1E, 36'h2A00FFFFF},  // R7 last byte of w0
    {36'h010100000, 1'b1, 4'h5, 8'h22, 36'h050100000},  // R11 first byte past w0
    {36'h00FFFFFFF, 1'b0, 4'h0, 8'h00, 36'h00FFFFFFF},  // R12 below all
    {36'h030000000, 1'b0, 4'h0, 8'h00, 36'h030000000},  // R8 disabled w2
    {36'h04000FFFF, 1'b1, 4'hC, 8'h99, 36'h04000FFFF},  // R5 R7 w19 64 KiB
    {36'h040010000, 1'b0, 4'h0, 8'h00, 36'h040010000}   // R7 one past w19
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int byte_off, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = RA_W'(byte_off / 4); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int byte_off, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = RA_W'(byte_off / 4);
    #1;
    chk(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic lk_chk(input string req, input logic [35:0] a, input logic h,
                        input logic [3:0] t, input logic [7:0] at, input logic [35:0] x);
    @(negedge clk);
    lk_addr = a;
    #1;
    chk({req, " hit"}, 64'(lk_hit), 64'(h));
    chk({req, " target"}, 64'(lk_target), 64'(t));
    chk({req, " attr"}, 64'(lk_attr), 64'(at));
    chk({req, " xaddr"}, 64'(lk_xaddr), 64'(x));
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 w0 ctrl", 'h00, 32'h0);
    rd_chk("R1 w9 ctrl", 'h98, 32'h0);
    rd_chk("R1 w0 remap lo", 'h08, 32'h0);
    lk_chk("R1 lookup", 36'h000000000, 1'b0, 4'h0, 8'h00, 36'h000000000);

    wr('h00, 32'h000F1E31); wr('h04, 32'h10000000); wr('h08, 32'hA0000000); wr('h0C, 32'h00000002);
    wr('h10, 32'h00FF2251); wr('h14, 32'h10000000); wr('h18, 32'h50000000); wr('h1C, 32'h00000000);
    wr('h20, 32'h00004440); wr('h24, 32'h30000000);
    wr('h98, 32'h00FF5571); wr('h9C, 32'h20000003);
    wr('hE8, 32'h000099C1); wr('hEC, 32'h40000000);

    // R2 control readback
    rd_chk("R2 w0 ctrl", 'h00, 32'h000F1E31);
    // R4 remap words of low window 0
    rd_chk("R4 w0 remap lo", 'h08, 32'hA0000000);
    rd_chk("R4 w0 remap hi", 'h0C, 32'h00000002);
    // R5 high window offsets
    rd_chk("R5 w19 ctrl", 'hE8, 32'h000099C1);
    rd_chk("R5 w9 base", 'h9C, 32'h20000003);
    // R3 base field masking
    wr('h34, 32'hFFFFFFFF);
    rd_chk("R3 w3 base", 'h34, 32'hFFFF000F);
    // R6 hole ignores writes and reads zero
    wr('h80, 32'hFFFFFFFF); wr('h84, 32'hFFFFFFFF);
    rd_chk("R6 hole 0x80", 'h80, 32'h0);
    rd_chk("R6 hole 0x84", 'h84, 32'h0);
    rd_chk("R6 w8 ctrl untouched", 'h90, 32'h0);
    rd_chk("R6 w7 remap hi untouched", 'h7C, 32'h0);

    for (int i = 0; i < NV; i++) begin
      lk_chk($sformatf("vec%0d R7", i), VEC[i][84:49], VEC[i][48], VEC[i][47:44],
             VEC[i][43:36], VEC[i][35:0]);
    end

    // R8 freeing window 1 by writing zero to its control word
    wr('h10, 32'h0);
    lk_chk("R8 freed w1", 36'h010F00010, 1'b0, 4'h0, 8'h00, 36'h010F00010);
    // R11 window 0 still wins in its range
    lk_chk("R11 w0 after free", 36'h010000000, 1'b1, 4'h3, 8'h1E, 36'h2A0000000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule